// File: doc/BRIEF.md
# Write-Sequenced Reset Controller

This block sits as a slave on a simple write bus and turns an ordered pair of register writes into a timed reset pulse for the rest of the system. Two kinds of reset can be requested. A hard reset drives the processor reset, an active-low PCI reset and the ISA reset-drive line. A soft reset drives only the processor INIT line. One reset only ever comes from a first write that arms a reset kind, followed by a second write that triggers it. A stray single write cannot reset the machine.

The block decodes two ways to reach it. One is a byte register in I/O space. The other is a pair of memory-space addresses that gives the same hard reset. The memory pair serves remote masters that can issue memory writes but cannot issue I/O writes. Once the trigger write is accepted, every selected output is held for a parameterised number of clock cycles. All of them then release on the same edge, and the block returns to its idle state.

Top module: `rstseq_ctrl`

## Requirements
- R1: In I/O space (`wr_space`=0) at address 0xCF9, writing 0x02 and then 0x06 starts a hard reset: `cpu_rst_o`=1, `pci_rst_n_o`=0, `isa_drv_o`=1, `init_o`=0.
- R2: In I/O space at 0xCF9, writing 0x00 and then 0x04 starts a soft reset: only `init_o`=1, and the three hard-reset outputs stay at their idle levels.
- R3: In memory space (`wr_space`=1), writing 0x02 to 0xFFFFFFF0 and then 0x06 to 0xFFFFFFF4 starts a hard reset with the same outputs as R1.
- R4: A trigger value (0x06 or 0x04 at 0xCF9, 0x06 at 0xFFFFFFF4) only fires when the matching arming write came last. Any other value written to one of the three reset addresses returns the block to idle. An arming value re-arms its own sequence.
- R5: Writes to any other address, or to a reset address in the other space, have no effect and leave the armed state in place.
- R6: Reset outputs assert in the cycle after the trigger write is sampled. They stay asserted for exactly PULSE_CYC cycles and release together.
- R7: Writes made while a pulse is active are ignored. After the pulse the block is idle, so a lone trigger write does not fire.
- R8: While `rst` is high all outputs are at their idle levels (`pci_rst_n_o`=1, the others 0). A reset also clears any armed sequence.
- R9: The hard-reset outputs and `init_o` are never asserted at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| wr_valid | input | 1 | A write is presented this cycle |
| wr_space | input | 1 | 0 = I/O space, 1 = memory space |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data (low byte) |
| cpu_rst_o | output | 1 | Processor reset, active high |
| pci_rst_n_o | output | 1 | PCI reset, active low |
| isa_drv_o | output | 1 | ISA reset-drive, active high |
| init_o | output | 1 | Processor INIT, active high |

## Verification
The bench builds the block with PULSE_CYC = 5 and the memory path enabled. With these values every pulse is short enough to run all 256 data values through each arming slot and each trigger slot, on both paths. The expected outcome of each trial is worked out arithmetically from the two byte values. The short pulse also makes it cheap to count the pulse length exactly on every trial that fires. It also lets the bench drive writes and a reset into the middle of a pulse.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   // classification of one accepted write
   typedef enum logic [2:0] {
      EV_NONE,
      EV_IO_ARM_H,
      EV_IO_ARM_S,
      EV_IO_GO_H,
      EV_IO_GO_S,
      EV_MEM_ARM,
      EV_MEM_GO,
      EV_CLEAR
   } wr_event_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_IO_HARD,
      ST_IO_SOFT,
      ST_MEM_HARD,
      ST_BUSY_HARD,
      ST_BUSY_SOFT
   } seq_state_t;

endpackage

// File: rtl/rstseq_decode.sv
module rstseq_decode
   import rstseq_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          DATA_W      = 8,
   parameter logic [31:0] IO_ADDR     = 32'h0000_0CF9,
   parameter logic [31:0] MEM_ADDR_A  = 32'hFFFF_FFF0,
   parameter logic [31:0] MEM_ADDR_B  = 32'hFFFF_FFF4,
   parameter bit          MEM_PATH_EN = 1'b1
) (
   input  logic              wr_valid,
   input  logic              wr_space,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output wr_event_t         ev
);
   localparam logic [DATA_W-1:0] V_ARM_H = DATA_W'(8'h02);
   localparam logic [DATA_W-1:0] V_ARM_S = DATA_W'(8'h00);
   localparam logic [DATA_W-1:0] V_GO_H  = DATA_W'(8'h06);
   localparam logic [DATA_W-1:0] V_GO_S  = DATA_W'(8'h04);

   logic hit_io, hit_a, hit_b;

   assign hit_io = wr_valid && !wr_space && (wr_addr == ADDR_W'(IO_ADDR));

   generate
      if (MEM_PATH_EN) begin : g_mem
         assign hit_a = wr_valid && wr_space && (wr_addr == ADDR_W'(MEM_ADDR_A));
         assign hit_b = wr_valid && wr_space && (wr_addr == ADDR_W'(MEM_ADDR_B));
      end else begin : g_nomem
         assign hit_a = 1'b0;
         assign hit_b = 1'b0;
      end
   endgenerate

   always_comb begin
      ev = EV_NONE;
      if (hit_io) begin
         unique case (wr_data)
            V_ARM_H: ev = EV_IO_ARM_H;
            V_ARM_S: ev = EV_IO_ARM_S;
            V_GO_H:  ev = EV_IO_GO_H;
            V_GO_S:  ev = EV_IO_GO_S;
            default: ev = EV_CLEAR;
         endcase
      end else if (hit_a) begin
         ev = (wr_data == V_ARM_H) ? EV_MEM_ARM : EV_CLEAR;
      end else if (hit_b) begin
         ev = (wr_data == V_GO_H) ? EV_MEM_GO : EV_CLEAR;
      end
   end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
   import rstseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  wr_event_t  ev,
   input  logic       expire,
   output logic       start,
   output seq_state_t state
);
   seq_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_BUSY_HARD, ST_BUSY_SOFT: if (expire) nxt = ST_IDLE;
         default: begin
            unique case (ev)
               EV_NONE:     nxt = state;
               EV_IO_ARM_H: nxt = ST_IO_HARD;
               EV_IO_ARM_S: nxt = ST_IO_SOFT;
               EV_MEM_ARM:  nxt = ST_MEM_HARD;
               EV_IO_GO_H:  nxt = (state == ST_IO_HARD)  ? ST_BUSY_HARD : ST_IDLE;
               EV_IO_GO_S:  nxt = (state == ST_IO_SOFT)  ? ST_BUSY_SOFT : ST_IDLE;
               EV_MEM_GO:   nxt = (state == ST_MEM_HARD) ? ST_BUSY_HARD : ST_IDLE;
               default:     nxt = ST_IDLE;
            endcase
         end
      endcase
   end

   assign start = (nxt == ST_BUSY_HARD || nxt == ST_BUSY_SOFT) &&
                  !(state == ST_BUSY_HARD || state == ST_BUSY_SOFT);

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= nxt;
   end

   // a pulse may only begin from the matching armed state
   AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
      (state == ST_BUSY_HARD && $past(state) != ST_BUSY_HARD) |->
         ($past(state) == ST_IO_HARD || $past(state) == ST_MEM_HARD)); // R4
   AST_SOFT_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
      (state == ST_BUSY_SOFT && $past(state) != ST_BUSY_SOFT) |->
         ($past(state) == ST_IO_SOFT)); // R4
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
   parameter int PULSE_CYC = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic active,
   output logic expire
);
   localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (start) begin
         active <= 1'b1;
         cnt    <= LOAD;
      end else if (active) begin
         if (cnt == '0) active <= 1'b0;
         else           cnt    <= cnt - 1'b1;
      end
   end

   assign expire = active && (cnt == '0);

   AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (rst)
      (active && cnt != '0) |=> active); // R6
   AST_ENDS_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (active && cnt == '0 && !start) |=> !active); // R6
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
   import rstseq_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          DATA_W      = 8,
   parameter int          PULSE_CYC   = 16,
   parameter logic [31:0] IO_ADDR     = 32'h0000_0CF9,
   parameter logic [31:0] MEM_ADDR_A  = 32'hFFFF_FFF0,
   parameter logic [31:0] MEM_ADDR_B  = 32'hFFFF_FFF4,
   parameter bit          MEM_PATH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_valid,
   input  logic              wr_space,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              cpu_rst_o,
   output logic              pci_rst_n_o,
   output logic              isa_drv_o,
   output logic              init_o
);
   generate
      if (PULSE_CYC < 1)          begin : g_bad_pulse $error("PULSE_CYC must be at least 1"); end
      if (DATA_W < 3)             begin : g_bad_data  $error("DATA_W must hold the control bits"); end
      if (ADDR_W < 12)            begin : g_bad_addr  $error("ADDR_W too narrow for I/O address"); end
      if (MEM_ADDR_A == MEM_ADDR_B) begin : g_bad_map $error("memory addresses must differ"); end
   endgenerate

   wr_event_t  ev;
   seq_state_t state;
   logic       start, active, expire;

   rstseq_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_ADDR(IO_ADDR),
      .MEM_ADDR_A(MEM_ADDR_A), .MEM_ADDR_B(MEM_ADDR_B), .MEM_PATH_EN(MEM_PATH_EN)
   ) u_decode (
      .wr_valid(wr_valid), .wr_space(wr_space), .wr_addr(wr_addr),
      .wr_data(wr_data), .ev(ev)
   );

   rstseq_fsm u_fsm (
      .clk(clk), .rst(rst), .ev(ev), .expire(expire),
      .start(start), .state(state)
   );

   rstseq_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
      .clk(clk), .rst(rst), .start(start),
      .active(active), .expire(expire)
   );

   logic hard_on;
   assign hard_on     = (state == ST_BUSY_HARD);
   assign cpu_rst_o   = hard_on;
   assign isa_drv_o   = hard_on;
   assign pci_rst_n_o = !hard_on;
   assign init_o      = (state == ST_BUSY_SOFT);

   AST_KIND_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(cpu_rst_o && init_o)); // R9
   AST_PULSE_TRACKS_TIMER: assert property (@(posedge clk) disable iff (rst)
      (cpu_rst_o || init_o) == active); // R6
   AST_IDLE_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
      $fell(active) |-> (state == ST_IDLE)); // R7
   AST_BUSY_IGNORES_WRITES: assert property (@(posedge clk) disable iff (rst)
      (active && !expire) |=> $stable(init_o) && $stable(cpu_rst_o)); // R7
endmodule

// File: tb/test_rstseq_ctrl.sv
module test_rstseq_ctrl;
   localparam int PC = 5;
   localparam logic [31:0] IOA = 32'h0000_0CF9;
   localparam logic [31:0] MA  = 32'hFFFF_FFF0;
   localparam logic [31:0] MB  = 32'hFFFF_FFF4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wr_valid = 1'b0, wr_space = 1'b0;
   logic [31:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic cpu_rst_o, pci_rst_n_o, isa_drv_o, init_o;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rstseq_ctrl #(.PULSE_CYC(PC)) i_rstseq_ctrl (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_space(wr_space),
      .wr_addr(wr_addr), .wr_data(wr_data), .cpu_rst_o(cpu_rst_o),
      .pci_rst_n_o(pci_rst_n_o), .isa_drv_o(isa_drv_o), .init_o(init_o)
   );

   task automatic do_write(input logic sp, input logic [31:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_space = sp; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic check_out(input bit eh, input bit es, input string req);
      logic [3:0] act, exp;
      act = {cpu_rst_o, pci_rst_n_o, isa_drv_o, init_o};
      exp = {eh, !eh, eh, es};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s outputs act=%b exp=%b", req, act, exp);
      end
   endtask

   task automatic check_pulse(input bit eh, input bit es, input string req);
      int n = 0;
      while ((cpu_rst_o || init_o) && n < 100) begin
         if ({cpu_rst_o, pci_rst_n_o, isa_drv_o, init_o} !== {eh, !eh, eh, es}) n = 1000;
         n++;
         @(negedge clk);
      end
      checks++;
      if (n != PC) begin
         fails++;
         $display("FAIL %s pulse length act=%0d exp=%0d", req, n, PC);
      end
   endtask

   task automatic trial(input logic s1, input logic [31:0] a1, input logic [7:0] d1,
                        input logic s2, input logic [31:0] a2, input logic [7:0] d2,
                        input bit eh, input bit es, input string req);
      do_write(1'b0, IOA, 8'hFF);
      do_write(s1, a1, d1);
      check_out(1'b0, 1'b0, req);
      do_write(s2, a2, d2);
      check_out(eh, es, req);
      if (eh || es) check_pulse(eh, es, req);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_out(1'b0, 1'b0, "R8 reset state");
      rst = 1'b0;
      @(negedge clk);

      // R1 / R4 sweep of arming value, trigger 0x06
      for (int v = 0; v < 256; v++)
         trial(0, IOA, 8'(v), 0, IOA, 8'h06, v == 2, 1'b0, "R1/R4 io arm sweep");
      // R2 / R4 sweep of arming value, trigger 0x04
      for (int v = 0; v < 256; v++)
         trial(0, IOA, 8'(v), 0, IOA, 8'h04, 1'b0, v == 0, "R2/R4 io soft arm sweep");
      // R1 / R4 trigger sweep after hard arm
      for (int v = 0; v < 256; v++)
         trial(0, IOA, 8'h02, 0, IOA, 8'(v), v == 6, 1'b0, "R1/R4 io trigger sweep");
      // R2 / R4 trigger sweep after soft arm
      for (int v = 0; v < 256; v++)
         trial(0, IOA, 8'h00, 0, IOA, 8'(v), 1'b0, v == 4, "R2/R4 soft trigger sweep");
      // R3 memory path sweeps
      for (int v = 0; v < 256; v++)
         trial(1, MA, 8'(v), 1, MB, 8'h06, v == 2, 1'b0, "R3 mem arm sweep");
      for (int v = 0; v < 256; v++)
         trial(1, MA, 8'h02, 1, MB, 8'(v), v == 6, 1'b0, "R3 mem trigger sweep");

      // R4 cross path and clear by another value
      trial(0, IOA, 8'h02, 1, MB, 8'h06, 1'b0, 1'b0, "R4 io arm then mem trigger");
      trial(1, MA, 8'h02, 0, IOA, 8'h06, 1'b0, 1'b0, "R4 mem arm then io trigger");
      do_write(0, IOA, 8'hFF);
      do_write(0, IOA, 8'h02);
      do_write(1, MA, 8'h55);
      do_write(0, IOA, 8'h06);
      check_out(1'b0, 1'b0, "R4 clear by other value at mem address");
      do_write(0, IOA, 8'h02);
      do_write(0, IOA, 8'h00);
      do_write(0, IOA, 8'h04);
      check_out(1'b0, 1'b1, "R4 re-arm to soft");
      check_pulse(1'b0, 1'b1, "R4 re-arm to soft");

      // R5 unrelated writes keep the armed state
      do_write(0, IOA, 8'h02);
      do_write(0, 32'h0000_0CFA, 8'h13);
      do_write(1, IOA, 8'h13);
      do_write(0, MA, 8'h13);
      do_write(1, 32'hFFFF_FFF8, 8'h00);
      do_write(0, IOA, 8'h06);
      check_out(1'b1, 1'b0, "R5 unrelated writes ignored");
      check_pulse(1'b1, 1'b0, "R5 unrelated writes ignored");

      // R7 writes during pulse ignored, idle afterwards
      do_write(0, IOA, 8'h02);
      do_write(0, IOA, 8'h06);
      do_write(0, IOA, 8'h00);
      do_write(0, IOA, 8'h04);
      check_out(1'b1, 1'b0, "R7 writes during pulse");
      repeat (PC) @(negedge clk);
      check_out(1'b0, 1'b0, "R7 pulse ended");
      do_write(0, IOA, 8'h04);
      check_out(1'b0, 1'b0, "R7 lone trigger after pulse");
      do_write(0, IOA, 8'h06);
      check_out(1'b0, 1'b0, "R7 lone hard trigger after pulse");

      // R8 reset clears armed state and an active pulse
      do_write(0, IOA, 8'h02);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      do_write(0, IOA, 8'h06);
      check_out(1'b0, 1'b0, "R8 reset clears arm");
      do_write(0, IOA, 8'h02);
      do_write(0, IOA, 8'h06);
      check_out(1'b1, 1'b0, "R8 pulse before reset");
      rst = 1'b1;
      @(negedge clk);
      check_out(1'b0, 1'b0, "R8 reset during pulse");
      rst = 1'b0;
      @(negedge clk);
      check_out(1'b0, 1'b0, "R8 stays idle after reset");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule